// File: doc/BRIEF.md
# ePaper Panel Bring-Up and Refresh Sequencer

This block drives an ePaper panel from power-up to a visible image with no processor in the loop. Once the chip leaves reset, it holds the panel reset line low for a fixed time derived from the clock frequency. It then sends a fixed setup sequence from an internal table. The setup sequence switches on the panel supplies, sets the pixel window and loads the refresh waveform bytes. Next it streams the frame buffer from an external synchronous block RAM, one byte per eight one-bit pixels. Last, it sends a short closing sequence whose final command makes the panel redraw.

Every byte leaves through a byte-wide valid/ready handshake toward a separate SPI serializer. A flag travels with each byte and marks it as data (1) or command (0). The sequencer never offers a new byte while the panel reports busy. After the closing command it waits for busy to drop and then raises a done flag. An update pulse given while done is high repeats the setup, frame and closing phases and leaves the panel reset line untouched.

Top module: `epaper_refresh_seq`

## Requirements
- R1: While rst_ni is low, panel_rst_no, tx_valid_o and done_o are 0. After rst_ni rises, panel_rst_no stays low for exactly RST_CYC = CLK_HZ/1e6*RST_US clock cycles and then stays high until the next rst_ni.
- R2: With no update pulse, the full sequence (setup, frame, closing) starts by itself after the panel reset time.
- R3: The setup phase sends these 13 bytes in this order, with flag 0=command and 1=data: 01(0) 03(1) 00(1) 04(0) 44(0) 00(1) 18(1) 45(0) 00(1) C7(1) 32(0) A5(1) 5A(1).
- R4: The frame phase reads RAM addresses 0 to FRAME_BYTES-1 in ascending order. RAM data arrive one cycle after the address. Each byte is sent with flag 1, the data value equal to the RAM word at that address.
- R5: The closing phase sends 22(0) C7(1) 20(0); 20 is the last byte and starts the panel refresh.
- R6: A byte is first offered (tx_valid_o rises) only when busy_i was low two cycles earlier. While busy_i stays high the sequencer offers nothing.
- R7: Once tx_valid_o is high it stays high, with tx_data_o and tx_dc_o unchanged, until a cycle with tx_ready_i high.
- R8: done_o rises only after the closing byte has been taken and busy_i has been seen low. It is never high together with tx_valid_o, and it stays high until an update pulse.
- R9: An update_i pulse while done_o is high clears done_o on the next cycle and replays the complete setup, frame and closing sequence, with panel_rst_no kept high.
- R10: update_i is ignored while a sequence is running: the byte stream is unchanged and complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| update_i | input | 1 | Restart request, acted on only while done |
| busy_i | input | 1 | Panel busy flag |
| panel_rst_no | output | 1 | Panel reset line, active low |
| tx_valid_o | output | 1 | Byte offered to the serializer |
| tx_ready_i | input | 1 | Serializer takes the byte this cycle |
| tx_data_o | output | 8 | Byte to send |
| tx_dc_o | output | 1 | 1 = data byte, 0 = command byte |
| ram_addr_o | output | ADDR_W | Frame RAM read address |
| ram_data_i | input | 8 | Frame RAM read data, one cycle after address |
| done_o | output | 1 | Sequence complete and panel idle |

## Verification
Three full passes are run. Each pass fills the frame RAM with its own pattern: the low address byte, a mixed inverted form of the address, and a multiplied form. A skipped, repeated or one-off address, or a missing RAM latency cycle, shows up as a wrong byte at a known stream position. The passes alternate between a serializer that is always ready and one that accepts only every third cycle, which separates correct holding of an offered byte from a byte that is dropped or replaced. Busy pulses of 3, 20 and 40 cycles follow each command byte, and one pass receives an update pulse in the middle of the frame stream. A correct design shows the stream continuing unchanged, while a design that wrongly restarts shows a duplicated setup prefix.

// File: rtl/epd_seq_pkg.sv
package epd_seq_pkg;

  typedef enum logic [2:0] {
    ST_POR,
    ST_WAIT,
    ST_LOAD,
    ST_SEND,
    ST_FLUSH,
    ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_PRE,
    PH_FRAME,
    PH_POST
  } seq_phase_e;

  localparam int PRE_LEN  = 13;
  localparam int POST_LEN = 3;

  // supplies on, x window, y window, waveform bytes
  localparam logic [7:0] PRE_BYTE [PRE_LEN] = '{
    8'h01, 8'h03, 8'h00, 8'h04, 8'h44, 8'h00, 8'h18,
    8'h45, 8'h00, 8'hC7, 8'h32, 8'hA5, 8'h5A
  };
  localparam logic PRE_IS_DATA [PRE_LEN] = '{
    1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1,
    1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1
  };

  // last entry triggers the panel redraw
  localparam logic [7:0] POST_BYTE [POST_LEN] = '{8'h22, 8'hC7, 8'h20};
  localparam logic POST_IS_DATA [POST_LEN] = '{1'b0, 1'b1, 1'b0};

endpackage

// File: rtl/epd_por_timer.sv
module epd_por_timer #(
  parameter int CYCLES = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic expired_o
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      expired_o <= 1'b0;
    end else if (!expired_o) begin
      if (cnt_q == CW'(CYCLES - 1)) expired_o <= 1'b1;
      else                          cnt_q     <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/epd_cfg_rom.sv
module epd_cfg_rom
  import epd_seq_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             post_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       byte_o,
  output logic             data_o
);

  localparam int PW = $clog2(PRE_LEN);
  localparam int QW = $clog2(POST_LEN);

  always_comb begin
    byte_o = '0;
    data_o = 1'b0;
    if (post_i) begin
      if (int'(idx_i) < POST_LEN) begin
        byte_o = POST_BYTE[idx_i[QW-1:0]];
        data_o = POST_IS_DATA[idx_i[QW-1:0]];
      end
    end else if (int'(idx_i) < PRE_LEN) begin
      byte_o = PRE_BYTE[idx_i[PW-1:0]];
      data_o = PRE_IS_DATA[idx_i[PW-1:0]];
    end
  end

endmodule

// File: rtl/epaper_refresh_seq.sv
module epaper_refresh_seq
  import epd_seq_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int RST_US      = 10_000,
  parameter int FRAME_BYTES = 5000,
  parameter int ADDR_W      = $clog2(FRAME_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              update_i,
  input  logic              busy_i,
  output logic              panel_rst_no,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_dc_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  input  logic [7:0]        ram_data_i,
  output logic              done_o
);

  localparam int RST_CYC = CLK_HZ / 1_000_000 * RST_US;

  seq_state_e        state_q;
  seq_phase_e        phase_q;
  logic [ADDR_W-1:0] idx_q;
  logic              por_done;
  logic [7:0]        rom_byte;
  logic              rom_data;
  logic              last_idx;

  epd_por_timer #(.CYCLES(RST_CYC)) u_por (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .expired_o (por_done)
  );

  epd_cfg_rom #(.IDX_W(ADDR_W)) u_rom (
    .post_i (phase_q == PH_POST),
    .idx_i  (idx_q),
    .byte_o (rom_byte),
    .data_o (rom_data)
  );

  always_comb begin
    unique case (phase_q)
      PH_PRE:   last_idx = (idx_q == ADDR_W'(PRE_LEN - 1));
      PH_FRAME: last_idx = (idx_q == ADDR_W'(FRAME_BYTES - 1));
      default:  last_idx = (idx_q == ADDR_W'(POST_LEN - 1));
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_POR;
      phase_q    <= PH_PRE;
      idx_q      <= '0;
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
      tx_dc_o    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_POR:   if (por_done) state_q <= ST_WAIT;
        ST_WAIT:  if (!busy_i) state_q <= ST_LOAD;
        // address has been stable a full cycle; RAM word is now valid
        ST_LOAD: begin
          tx_data_o  <= (phase_q == PH_FRAME) ? ram_data_i : rom_byte;
          tx_dc_o    <= (phase_q == PH_FRAME) ? 1'b1 : rom_data;
          tx_valid_o <= 1'b1;
          state_q    <= ST_SEND;
        end
        ST_SEND: begin
          if (tx_ready_i) begin
            tx_valid_o <= 1'b0;
            if (last_idx) begin
              idx_q <= '0;
              unique case (phase_q)
                PH_PRE: begin
                  phase_q <= PH_FRAME;
                  state_q <= ST_WAIT;
                end
                PH_FRAME: begin
                  phase_q <= PH_POST;
                  state_q <= ST_WAIT;
                end
                default: state_q <= ST_FLUSH;
              endcase
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_WAIT;
            end
          end
        end
        ST_FLUSH: if (!busy_i) state_q <= ST_DONE;
        ST_DONE: begin
          if (update_i) begin
            phase_q <= PH_PRE;
            idx_q   <= '0;
            state_q <= ST_WAIT;
          end
        end
        default: state_q <= ST_POR;
      endcase
    end
  end

  assign panel_rst_no = por_done;
  assign ram_addr_o   = idx_q;
  assign done_o       = (state_q == ST_DONE);

endmodule

// File: rtl/epaper_refresh_seq_chk.sv
module epaper_refresh_seq_chk #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int RST_US      = 10_000,
  parameter int FRAME_BYTES = 5000,
  parameter int ADDR_W      = $clog2(FRAME_BYTES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              update_i,
  input logic              busy_i,
  input logic              panel_rst_no,
  input logic              tx_valid_o,
  input logic              tx_ready_i,
  input logic [7:0]        tx_data_o,
  input logic              tx_dc_o,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic              done_o
);

  localparam int RST_CYC = CLK_HZ / 1_000_000 * RST_US;
  localparam int LW      = $clog2(RST_CYC + 2);

  logic [LW-1:0] low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          low_cnt_q <= '0;
    else if (!panel_rst_no && low_cnt_q != LW'(RST_CYC + 1)) low_cnt_q <= low_cnt_q + 1'b1;
  end

  assert_rst_len_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(panel_rst_no) |-> low_cnt_q == LW'(RST_CYC));

  assert_rst_max_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !panel_rst_no |-> low_cnt_q < LW'(RST_CYC));

  assert_rst_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    panel_rst_no |=> panel_rst_no);

  assert_addr_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(ram_addr_o) < FRAME_BYTES);

  assert_busy_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_o) |-> !$past(busy_i, 2));

  assert_offer_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_dc_o));

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> !$past(busy_i) && !tx_valid_o);

  assert_done_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !update_i |=> done_o);

  assert_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && update_i |=> !done_o && panel_rst_no);

endmodule

bind epaper_refresh_seq epaper_refresh_seq_chk #(
  .CLK_HZ      (CLK_HZ),
  .RST_US      (RST_US),
  .FRAME_BYTES (FRAME_BYTES),
  .ADDR_W      (ADDR_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .update_i     (update_i),
  .busy_i       (busy_i),
  .panel_rst_no (panel_rst_no),
  .tx_valid_o   (tx_valid_o),
  .tx_ready_i   (tx_ready_i),
  .tx_data_o    (tx_data_o),
  .tx_dc_o      (tx_dc_o),
  .ram_addr_o   (ram_addr_o),
  .done_o       (done_o)
);

// File: tb/tb_epaper_refresh_seq.sv
module tb_epaper_refresh_seq;

  localparam int CLKHZ = 50_000_000;
  localparam int RUS   = 2;
  localparam int FB    = 5000;
  localparam int AW    = $clog2(FB);
  localparam int RCYC  = CLKHZ / 1_000_000 * RUS;
  localparam int PREN  = 13;
  localparam int POSTN = 3;
  localparam int NTOT  = PREN + FB + POSTN;
  localparam int NROW  = 3;

  // R3 / R5 expected bytes and flags
  localparam logic [7:0] X_PRE [PREN] = '{8'h01, 8'h03, 8'h00, 8'h04, 8'h44, 8'h00, 8'h18,
                                          8'h45, 8'h00, 8'hC7, 8'h32, 8'hA5, 8'h5A};
  localparam logic X_PRE_D [PREN] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1,
                                      1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic [7:0] X_POST [POSTN] = '{8'h22, 8'hC7, 8'h20};
  localparam logic X_POST_D [POSTN] = '{1'b0, 1'b1, 1'b0};

  // row: ready mode, RAM pattern, busy length, mid-run update, expected byte count
  localparam int V_MODE [NROW] = '{0, 1, 0};
  localparam int V_PAT  [NROW] = '{0, 1, 2};
  localparam int V_BUSY [NROW] = '{20, 3, 40};
  localparam int V_MID  [NROW] = '{0, 1, 0};
  localparam int V_NEXP [NROW] = '{NTOT, NTOT, NTOT};

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          update_i;
  logic          busy_i;
  logic          panel_rst_no;
  logic          tx_valid_o;
  logic          tx_ready_i;
  logic [7:0]    tx_data_o;
  logic          tx_dc_o;
  logic [AW-1:0] ram_addr_o;
  logic [7:0]    ram_data_i = '0;
  logic          done_o;

  always #10 clk_i = ~clk_i;

  epaper_refresh_seq #(
    .CLK_HZ(CLKHZ), .RST_US(RUS), .FRAME_BYTES(FB)
  ) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .update_i(update_i), .busy_i(busy_i),
    .panel_rst_no(panel_rst_no), .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i),
    .tx_data_o(tx_data_o), .tx_dc_o(tx_dc_o), .ram_addr_o(ram_addr_o),
    .ram_data_i(ram_data_i), .done_o(done_o)
  );

  int total = 0, bad = 0;
  int mode = 0, pat_sel = 0, blen = 0;
  int seq = 0, cyc = 0, bcnt = 0;
  int mm_pre = 0, mm_frm = 0, mm_post = 0, v_busy = 0, v_done = 0, v_hold = 0;
  int f_act = 0, f_exp = 0;
  bit pend = 1'b0, prev_v = 1'b0, prev_r = 1'b0;
  logic [8:0] prev_w = '0;

  function automatic logic [7:0] pat(int p, int a);
    int v;
    case (p)
      0:       v = a;
      1:       v = ~a ^ (a >> 5);
      default: v = a * 37 + 92;
    endcase
    return v[7:0];
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // synchronous RAM, one cycle read latency (R4)
  initial forever begin
    @(posedge clk_i);
    ram_data_i <= pat(pat_sel, int'(ram_addr_o));
  end

  // panel and serializer model plus stream monitor
  initial forever begin
    logic [8:0] e, a;
    @(negedge clk_i);
    cyc++;
    if (pend) begin bcnt = blen; pend = 1'b0; end
    busy_i = (bcnt != 0);
    if (bcnt != 0) bcnt--;
    tx_ready_i = (mode == 0) ? 1'b1 : (cyc % 3 == 0);
    #1;
    if (rst_ni === 1'b1) begin
      a = {tx_dc_o, tx_data_o};
      if (tx_valid_o && !prev_v && busy_i) v_busy++;
      if (done_o && (busy_i || tx_valid_o)) v_done++;
      if (prev_v && !prev_r && (!tx_valid_o || a != prev_w)) v_hold++;
      if (tx_valid_o && tx_ready_i) begin
        if (seq < PREN) begin
          e = {X_PRE_D[seq], X_PRE[seq]};
          if (a != e) mm_pre++;
        end else if (seq < PREN + FB) begin
          e = {1'b1, pat(pat_sel, seq - PREN)};
          if (a != e) begin
            if (mm_frm == 0) begin f_act = int'(a); f_exp = int'(e); end
            mm_frm++;
          end
        end else if (seq < NTOT) begin
          e = {X_POST_D[seq - PREN - FB], X_POST[seq - PREN - FB]};
          if (a != e) mm_post++;
        end else mm_post++;
        if (!tx_dc_o) pend = 1'b1;
        seq++;
      end
      prev_w = a;
    end
    prev_v = tx_valid_o;
    prev_r = tx_ready_i;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    rst_ni   = 1'b0;
    update_i = 1'b0;
    busy_i   = 1'b0;
    tx_ready_i = 1'b0;
    for (int r = 0; r < NROW; r++) begin
      @(negedge clk_i);
      mode = V_MODE[r]; pat_sel = V_PAT[r]; blen = V_BUSY[r];
      seq = 0; mm_pre = 0; mm_frm = 0; mm_post = 0;
      v_busy = 0; v_done = 0; v_hold = 0;
      if (r == 0) begin
        repeat (3) @(negedge clk_i);
        #2;
        chk(panel_rst_no == 1'b0, "R1 panel reset in reset", int'(panel_rst_no), 0);
        chk(tx_valid_o == 1'b0, "R1 valid in reset", int'(tx_valid_o), 0);
        chk(done_o == 1'b0, "R1 done in reset", int'(done_o), 0);
        @(negedge clk_i);
        bcnt = 20;
        rst_ni = 1'b1;
        begin
          int lc = 0;
          while (panel_rst_no === 1'b0 && lc < RCYC + 10) begin
            lc++;
            @(negedge clk_i);
          end
          chk(lc == RCYC, "R1 panel reset length", lc, RCYC);
        end
      end else begin
        update_i = 1'b1;
        @(negedge clk_i);
        update_i = 1'b0;
        #2;
        chk(done_o == 1'b0, "R9 done cleared by update", int'(done_o), 0);
        chk(panel_rst_no == 1'b1, "R9 panel reset untouched", int'(panel_rst_no), 1);
      end
      if (V_MID[r] != 0) begin
        while (seq < PREN + 100) @(negedge clk_i);
        update_i = 1'b1;
        @(negedge clk_i);
        update_i = 1'b0;
      end
      while (done_o !== 1'b1) @(negedge clk_i);
      #2;
      if (r == 0) chk(seq == V_NEXP[r], "R2 auto start full stream", seq, V_NEXP[r]);
      else        chk(seq == V_NEXP[r], "R9 replay full stream", seq, V_NEXP[r]);
      chk(mm_pre == 0, "R3 setup bytes", mm_pre, 0);
      chk(mm_frm == 0, "R4 frame bytes", f_act, f_exp);
      chk(mm_post == 0, "R5 closing bytes", mm_post, 0);
      chk(v_busy == 0, "R6 offer while busy", v_busy, 0);
      chk(v_hold == 0, "R7 offer held until ready", v_hold, 0);
      chk(v_done == 0, "R8 done while busy or offering", v_done, 0);
      if (V_MID[r] != 0)
        chk(seq == NTOT && mm_pre == 0, "R10 mid-run update ignored", seq, NTOT);
      repeat (10) @(negedge clk_i);
      #2;
      chk(done_o == 1'b1, "R8 done holds", int'(done_o), 1);
      chk(seq == V_NEXP[r], "R8 no bytes after done", seq, V_NEXP[r]);
    end
    summary();
  end

endmodule